// File: doc/BRIEF.md
# Raster Scan Timing Generator with Underrun Hold

This block drives a display raster. Two counters walk a programmable frame: a pixel counter along each line and a line counter down the frame. Each axis steps through four programmable regions in a fixed order: sync pulse, back porch, visible area, front porch. From these counters the block produces horizontal sync, vertical sync, a data-enable strobe and the pixel bus. It takes exactly one word from an external line FIFO for each visible pixel.

If the FIFO is empty on a visible pixel, the block does not stall. It raises a single underrun event, stops drawing from the FIFO, and repeats the last pixel it emitted until the frame ends. Normal fetching resumes at the start of the next frame. The block also gives a start-of-vertical-sync event to an interrupt collector and a frame-done event to the fetch engine, so that the engine can be rearmed.

Every output polarity is selectable, and a single enable line starts and stops the whole raster.

Top module: `disp_timing_gen`

## Requirements
- R1: All outputs are registered and reflect the counter position of the previous clock. Along a line the regions are sync, back porch, visible area and front porch, in that order. Each region lasts its programmed 12-bit value plus one clocks, so a line lasts the sum of the four. Horizontal sync is active during the sync region.
- R2: The line counter advances once per line wrap and uses the same four regions, counted in lines; the frame wraps after the last front-porch line. Vertical sync is active during the vertical sync lines.
- R3: Data enable is active only when both axes are in their visible region. `fifoPop` is high, in the same cycle, exactly on enabled visible pixels where the FIFO is not empty and no underrun hold is in force.
- R4: A popped FIFO word appears on `pixOut` one clock later. Outside visible pixels `pixOut` is zero.
- R5: Each bit of `polCfg` inverts one output. Bit 0 inverts vertical sync, bit 1 inverts horizontal sync, bit 2 inverts data enable, and bit 3 inverts every pixel bit during visible pixels. Bit 4 is driven on `clkInvOut` one clock later.
- R6: On a visible pixel where the FIFO is empty and no hold is in force, `underrunEvt` pulses for one clock. The pulse occurs at most once per frame.
- R7: After an underrun, no more words are popped in that frame, and every remaining visible pixel repeats the last emitted pixel value. The hold ends at the frame wrap.
- R8: `vsyncEvt` pulses for one clock at the first clock of each frame, which is the first vertical sync clock.
- R9: `frameDoneEvt` pulses for one clock on the last visible pixel of the last visible line.
- R10: While `runEn` is low, both counters return to the frame start and any hold is cleared. Sync and enable outputs sit at their inactive level, which equals their polarity bit. `pixOut` is zero, and no pop and no event occurs. After `runEn` rises, the raster restarts at the first sync clock.
- R11: While reset is asserted, every output, including `fifoPop`, is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Global raster enable |
| polCfg | input | 5 | Output polarity selects |
| hSyncLen | input | 12 | Horizontal sync width minus one |
| hBackLen | input | 12 | Horizontal back porch width minus one |
| hActLen | input | 12 | Visible pixels per line minus one |
| hFrontLen | input | 12 | Horizontal front porch width minus one |
| vSyncLen | input | 12 | Vertical sync lines minus one |
| vBackLen | input | 12 | Vertical back porch lines minus one |
| vActLen | input | 12 | Visible lines minus one |
| vFrontLen | input | 12 | Vertical front porch lines minus one |
| fifoEmpty | input | 1 | Line FIFO has no word |
| fifoData | input | 24 | Line FIFO head word |
| fifoPop | output | 1 | Take the head word this clock |
| hSyncOut | output | 1 | Horizontal sync |
| vSyncOut | output | 1 | Vertical sync |
| dataEnOut | output | 1 | Data enable |
| pixOut | output | 24 | Pixel bus |
| clkInvOut | output | 1 | Pixel clock inversion select |
| vsyncEvt | output | 1 | Start-of-vertical-sync pulse |
| underrunEvt | output | 1 | Underrun pulse |
| frameDoneEvt | output | 1 | Last visible pixel pulse |

## Verification
Underrun detection and the frame-done event can fall in the same clock. The bench provokes this by emptying the FIFO on exactly the last visible pixel of the last visible line. It then expects both pulses in the same cycle and the repeated pixel on the bus. It also checks that the hold has gone at the next frame, so that fetching and fresh pixels resume from the first visible pixel. Every cycle is compared against an arithmetic raster model driven from the programmed widths. The comparison covers two small geometries, several polarity settings, mid-frame disables and a second empty FIFO inside an already held frame.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_DATA  = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  // strobes from control to datapath, one per pixel clock
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic pop;
    logic urEvt;
    logic vsEvt;
    logic fdEvt;
  } strobe_t;
endpackage

// File: rtl/tg_axis.sv
module tg_axis
  import tg_pkg::*;
#(
  parameter int CW = 12,
  parameter int SW = CW + 3
) (
  input  logic [SW-1:0] cnt,
  input  logic [CW-1:0] wSync,
  input  logic [CW-1:0] wBack,
  input  logic [CW-1:0] wAct,
  input  logic [CW-1:0] wFront,
  output phase_e        phase,
  output logic          atEnd,
  output logic          atActEnd
);
  logic [SW-1:0] bSync, bBack, bAct, bFront;

  // region boundaries: each region lasts programmed value plus one
  always_comb begin
    bSync  = SW'(wSync) + SW'(1);
    bBack  = bSync + SW'(wBack) + SW'(1);
    bAct   = bBack + SW'(wAct) + SW'(1);
    bFront = bAct + SW'(wFront) + SW'(1);
  end

  always_comb begin
    if (cnt < bSync)      phase = PH_SYNC;
    else if (cnt < bBack) phase = PH_BACK;
    else if (cnt < bAct)  phase = PH_DATA;
    else                  phase = PH_FRONT;
  end

  assign atEnd    = (cnt == bFront - SW'(1));
  assign atActEnd = (cnt == bAct - SW'(1));
endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
#(
  parameter int CW = 12,
  parameter int SW = CW + 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      runEn,
  input  logic [1:0][3:0][CW-1:0]   wCfg,
  input  logic                      fifoEmpty,
  output strobe_t                   st
);
  logic [SW-1:0] hCnt, vCnt;
  logic          holdFlag;
  logic [1:0][SW-1:0] cntVec;
  phase_e        axPh [2];
  logic [1:0]    axEnd, axActEnd;
  logic          frameWrap, visible, urNow;

  assign cntVec = {vCnt, hCnt};

  for (genvar a = 0; a < 2; a++) begin : g_axis
    tg_axis #(.CW(CW), .SW(SW)) u_axis (
      .cnt      (cntVec[a]),
      .wSync    (wCfg[a][0]),
      .wBack    (wCfg[a][1]),
      .wAct     (wCfg[a][2]),
      .wFront   (wCfg[a][3]),
      .phase    (axPh[a]),
      .atEnd    (axEnd[a]),
      .atActEnd (axActEnd[a])
    );
  end

  assign frameWrap = axEnd[0] & axEnd[1];
  assign visible   = runEn & (axPh[0] == PH_DATA) & (axPh[1] == PH_DATA);
  assign urNow     = visible & fifoEmpty & ~holdFlag;

  always_comb begin
    st.hs    = runEn & (axPh[0] == PH_SYNC);
    st.vs    = runEn & (axPh[1] == PH_SYNC);
    st.de    = visible;
    st.pop   = visible & ~fifoEmpty & ~holdFlag;
    st.urEvt = urNow;
    st.vsEvt = runEn & (hCnt == '0) & (vCnt == '0);
    st.fdEvt = visible & axActEnd[0] & axActEnd[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt     <= '0;
      vCnt     <= '0;
      holdFlag <= 1'b0;
    end else if (!runEn) begin
      hCnt     <= '0;
      vCnt     <= '0;
      holdFlag <= 1'b0;
    end else begin
      hCnt <= axEnd[0] ? '0 : hCnt + SW'(1);
      if (axEnd[0]) vCnt <= axEnd[1] ? '0 : vCnt + SW'(1);
      if (frameWrap)  holdFlag <= 1'b0;
      else if (urNow) holdFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/tg_dpath.sv
module tg_dpath
  import tg_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [4:0]    polCfg,
  input  logic [PW-1:0] fifoData,
  output logic          hSyncOut,
  output logic          vSyncOut,
  output logic          dataEnOut,
  output logic [PW-1:0] pixOut,
  output logic          clkInvOut,
  output logic          vsyncEvt,
  output logic          underrunEvt,
  output logic          frameDoneEvt
);
  logic [PW-1:0] lastPix, curPix;

  // a held frame keeps emitting the last accepted word
  assign curPix = st.pop ? fifoData : lastPix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPix      <= '0;
      hSyncOut     <= 1'b0;
      vSyncOut     <= 1'b0;
      dataEnOut    <= 1'b0;
      pixOut       <= '0;
      clkInvOut    <= 1'b0;
      vsyncEvt     <= 1'b0;
      underrunEvt  <= 1'b0;
      frameDoneEvt <= 1'b0;
    end else begin
      if (st.pop) lastPix <= fifoData;
      vSyncOut     <= st.vs ^ polCfg[0];
      hSyncOut     <= st.hs ^ polCfg[1];
      dataEnOut    <= st.de ^ polCfg[2];
      pixOut       <= st.de ? (curPix ^ {PW{polCfg[3]}}) : '0;
      clkInvOut    <= polCfg[4];
      vsyncEvt     <= st.vsEvt;
      underrunEvt  <= st.urEvt;
      frameDoneEvt <= st.fdEvt;
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tg_pkg::*;
#(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic [4:0]    polCfg,
  input  logic [CW-1:0] hSyncLen,
  input  logic [CW-1:0] hBackLen,
  input  logic [CW-1:0] hActLen,
  input  logic [CW-1:0] hFrontLen,
  input  logic [CW-1:0] vSyncLen,
  input  logic [CW-1:0] vBackLen,
  input  logic [CW-1:0] vActLen,
  input  logic [CW-1:0] vFrontLen,
  input  logic          fifoEmpty,
  input  logic [PW-1:0] fifoData,
  output logic          fifoPop,
  output logic          hSyncOut,
  output logic          vSyncOut,
  output logic          dataEnOut,
  output logic [PW-1:0] pixOut,
  output logic          clkInvOut,
  output logic          vsyncEvt,
  output logic          underrunEvt,
  output logic          frameDoneEvt
);
  localparam int SW = CW + 3;

  strobe_t st;
  logic [1:0][3:0][CW-1:0] wCfg;

  assign wCfg = {vFrontLen, vActLen, vBackLen, vSyncLen,
                 hFrontLen, hActLen, hBackLen, hSyncLen};
  assign fifoPop = st.pop;

  tg_ctrl #(.CW(CW), .SW(SW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .wCfg      (wCfg),
    .fifoEmpty (fifoEmpty),
    .st        (st)
  );

  tg_dpath #(.PW(PW)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .polCfg       (polCfg),
    .fifoData     (fifoData),
    .hSyncOut     (hSyncOut),
    .vSyncOut     (vSyncOut),
    .dataEnOut    (dataEnOut),
    .pixOut       (pixOut),
    .clkInvOut    (clkInvOut),
    .vsyncEvt     (vsyncEvt),
    .underrunEvt  (underrunEvt),
    .frameDoneEvt (frameDoneEvt)
  );
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          runEn,
  input logic [4:0]    polCfg,
  input logic          fifoEmpty,
  input logic          fifoPop,
  input logic          dataEnOut,
  input logic [PW-1:0] pixOut,
  input logic          underrunEvt,
  input logic          vsyncEvt,
  input logic          frameDoneEvt
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R3: a pop only ever takes a present word while running
  p_pop_needs_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (!fifoEmpty && runEn));

  // R10: no pop while stopped
  p_idle_no_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !fifoPop);

  // R7: the clock after an underrun pulse, the hold blocks popping
  p_hold_blocks_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    underrunEvt |-> !fifoPop);

  // R6: underrun is a single-clock pulse
  p_ur_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    underrunEvt |=> !underrunEvt);

  // R8: vertical sync event is a single-clock pulse
  p_vs_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    vsyncEvt |=> !vsyncEvt);

  // R9: frame done is a single-clock pulse
  p_fd_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameDoneEvt |=> !frameDoneEvt);

  // R4: blank pixels are zero
  p_blank_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $stable(polCfg) && (dataEnOut == polCfg[2])) |-> (pixOut == '0));

  // R10: one clock after a stopped cycle the outputs are quiet
  p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!runEn)) |-> (pixOut == '0 && !vsyncEvt && !underrunEvt && !frameDoneEvt));
endmodule

bind disp_timing_gen disp_timing_gen_chk #(.PW(PW)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .runEn        (runEn),
  .polCfg       (polCfg),
  .fifoEmpty    (fifoEmpty),
  .fifoPop      (fifoPop),
  .dataEnOut    (dataEnOut),
  .pixOut       (pixOut),
  .underrunEvt  (underrunEvt),
  .vsyncEvt     (vsyncEvt),
  .frameDoneEvt (frameDoneEvt)
);

// File: tb/disp_timing_gen_bench.sv
`timescale 1ns/1ps
module disp_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [4:0]  polCfg = '0;
  logic [11:0] hSyncLen, hBackLen, hActLen, hFrontLen;
  logic [11:0] vSyncLen, vBackLen, vActLen, vFrontLen;
  logic        fifoEmpty = 1'b0;
  logic [23:0] fifoData = 24'h100001;
  logic        fifoPop, hSyncOut, vSyncOut, dataEnOut, clkInvOut;
  logic [23:0] pixOut;
  logic        vsyncEvt, underrunEvt, frameDoneEvt;

  int total = 0;
  int bad = 0;

  // reference model state
  int hw[4];
  int vw[4];
  int mIdx = 0;
  bit mHold = 0;
  logic [23:0] mLast = '0;

  always #10 clk = ~clk;

  disp_timing_gen u_disp_timing_gen (
    .clk(clk), .rstN(rstN), .runEn(runEn), .polCfg(polCfg),
    .hSyncLen(hSyncLen), .hBackLen(hBackLen), .hActLen(hActLen), .hFrontLen(hFrontLen),
    .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vActLen(vActLen), .vFrontLen(vFrontLen),
    .fifoEmpty(fifoEmpty), .fifoData(fifoData), .fifoPop(fifoPop),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .dataEnOut(dataEnOut), .pixOut(pixOut),
    .clkInvOut(clkInvOut), .vsyncEvt(vsyncEvt), .underrunEvt(underrunEvt),
    .frameDoneEvt(frameDoneEvt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h idx=%0d t=%0t", tag, act, exp, mIdx, $time);
    end
  endtask

  task automatic setGeom(input int h0, h1, h2, h3, v0, v1, v2, v3);
    hSyncLen = 12'(h0); hBackLen = 12'(h1); hActLen = 12'(h2); hFrontLen = 12'(h3);
    vSyncLen = 12'(v0); vBackLen = 12'(v1); vActLen = 12'(v2); vFrontLen = 12'(v3);
    hw[0] = h0 + 1; hw[1] = h1 + 1; hw[2] = h2 + 1; hw[3] = h3 + 1;
    vw[0] = v0 + 1; vw[1] = v1 + 1; vw[2] = v2 + 1; vw[3] = v3 + 1;
  endtask

  function automatic int hTot();
    return hw[0] + hw[1] + hw[2] + hw[3];
  endfunction

  function automatic int frameLen();
    return hTot() * (vw[0] + vw[1] + vw[2] + vw[3]);
  endfunction

  function automatic int nthVisible(input int line, input int px);
    return (vw[0] + vw[1] + line) * hTot() + hw[0] + hw[1] + px;
  endfunction

  // one pixel clock; called at a falling edge
  task automatic tick(input bit emptyNow);
    int h, v;
    bit de, hs, vs, pop, ur, vse, fde;
    logic [23:0] expPix;
    string tg;
    fifoEmpty = emptyNow;
    #1;
    h = mIdx % hTot();
    v = mIdx / hTot();
    hs = runEn && (h < hw[0]);
    vs = runEn && (v < vw[0]);
    de = runEn && (h >= hw[0] + hw[1]) && (h < hw[0] + hw[1] + hw[2])
              && (v >= vw[0] + vw[1]) && (v < vw[0] + vw[1] + vw[2]);
    pop = de && !emptyNow && !mHold;
    ur  = de && emptyNow && !mHold;
    vse = runEn && (mIdx == 0);
    fde = de && (h == hw[0] + hw[1] + hw[2] - 1) && (v == vw[0] + vw[1] + vw[2] - 1);
    expPix = de ? ((pop ? fifoData : mLast) ^ {24{polCfg[3]}}) : 24'h0;
    chk(runEn ? (mHold ? "R7 pop" : "R3 pop") : "R10 pop", 32'(fifoPop), 32'(pop));
    @(posedge clk);
    @(negedge clk);
    chk(runEn ? "R1 hsync" : "R10 hsync", 32'(hSyncOut), 32'(hs ^ polCfg[1]));
    chk(runEn ? "R2 vsync" : "R10 vsync", 32'(vSyncOut), 32'(vs ^ polCfg[0]));
    chk(runEn ? "R3 de" : "R10 de", 32'(dataEnOut), 32'(de ^ polCfg[2]));
    if (!runEn)      tg = "R10 pix";
    else if (mHold || ur) tg = "R7 pix";
    else if (polCfg[3]) tg = "R5 pix";
    else             tg = "R4 pix";
    chk(tg, 32'(pixOut), 32'(expPix));
    chk("R5 clkinv", 32'(clkInvOut), 32'(polCfg[4]));
    chk(runEn ? "R6 underrun" : "R10 underrun", 32'(underrunEvt), 32'(ur));
    chk(runEn ? "R8 vsevt" : "R10 vsevt", 32'(vsyncEvt), 32'(vse));
    chk(runEn ? "R9 done" : "R10 done", 32'(frameDoneEvt), 32'(fde));
    if (!runEn) begin
      mIdx = 0;
      mHold = 0;
    end else begin
      if (pop) begin
        mLast = fifoData;
        fifoData = fifoData + 24'h010203;
      end
      if (ur) mHold = 1;
      if (mIdx == frameLen() - 1) begin
        mIdx = 0;
        mHold = 0;
      end else begin
        mIdx++;
      end
    end
  endtask

  task automatic runFrame(input int e1, input int e2);
    for (int j = frameLen(); j > 0; j--) begin
      tick((mIdx == e1) || (mIdx == e2));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // geometry A: line 2+1+4+2 = 9 clocks, frame 1+1+3+1 = 6 lines
    setGeom(1, 0, 3, 1, 0, 0, 2, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 pop", 32'(fifoPop), 0);
    chk("R11 outs", 32'({hSyncOut, vSyncOut, dataEnOut, clkInvOut,
                         vsyncEvt, underrunEvt, frameDoneEvt}), 0);
    chk("R11 pix", 32'(pixOut), 0);
    rstN = 1'b1;
    tick(0);
    tick(0);
    runEn = 1'b1;
    runFrame(-1, -1);
    runFrame(-1, -1);
    // mid-frame underrun, then a second empty in the held frame (R6 once, R7 hold)
    runFrame(nthVisible(1, 1), nthVisible(2, 1));
    // next frame resumes normally (R7)
    runFrame(-1, -1);
    // underrun on the very last visible pixel, coinciding with frame done (R6, R9)
    runFrame(nthVisible(2, 3), -1);
    runFrame(-1, -1);
    // all polarities inverted (R5, R10)
    runEn = 1'b0;
    repeat (3) tick(0);
    polCfg = 5'b11111;
    repeat (2) tick(0);
    runEn = 1'b1;
    runFrame(nthVisible(0, 2), -1);
    runFrame(-1, -1);
    // disable mid-frame and restart (R10)
    repeat (20) tick(0);
    runEn = 1'b0;
    repeat (4) tick(0);
    runEn = 1'b1;
    runFrame(-1, -1);
    // geometry B with zero widths: line 1+2+2+1 = 6, frame 2+1+2+1 = 6 lines
    runEn = 1'b0;
    polCfg = 5'b01010;
    setGeom(0, 1, 1, 0, 1, 0, 1, 0);
    repeat (2) tick(0);
    runEn = 1'b1;
    runFrame(nthVisible(0, 0), -1);
    runFrame(-1, -1);
    polCfg = 5'b00101;
    runEn = 1'b0;
    tick(0);
    runEn = 1'b1;
    runFrame(nthVisible(1, 1), nthVisible(1, 0));
    runFrame(-1, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule